// File: doc/BRIEF.md
# Pipelined Multiply-Add Datapath Slice

This block is one arithmetic slice for filters, accumulators and wide adders. A signed 25-bit operand and a signed 18-bit operand are multiplied. Three operand multiplexers, named X, Y and Z, pick the sources for a 48-bit arithmetic/logic unit. The sources include the product, the C input, a partial sum cascaded in from a neighbouring slice, the slice's own output and shifted copies of these. The result goes out on `p`. The same value also leaves on `pc_cas`, so the next slice can chain from it.

Every stage can be a register or a plain wire, and this is chosen at elaboration time. The stages are two A-input stages, two B-input stages, C, the product, the output and the four control fields. Each present register has its own active-high synchronous reset and its own clock enable. A global reset is ORed into every local reset, and a global enable is ANDed into every local enable.

A single packed 15-bit instruction word carries all control fields. The A and B cascade outputs tap their input pipelines at a depth set by separate parameters.

Top module: `mac_slice`

## Requirements
- R1: Operand select X=1 feeds the signed product of `a` (25 bits) and `b` (18 bits), sign-extended to 48 bits, so operand extremes give the exact two's-complement product.
- R2: `instr` bits 6:0 are the operand select, bits 10:7 the ALU code, bit 11 the carry bit and bits 14:12 the carry source. In the operand select, bits 1:0 choose X (0 zero, 1 product, 2 fed-back P, 3 `{5'b0,A,B}`). Bits 3:2 choose Y (0 zero, 1 all ones, 2 C, 3 zero). Bits 6:4 choose Z (0 zero, 1 `pc_in`, 2 fed-back P, 3 C, 4 `pc_in` arithmetic-shifted right by 17, 5 fed-back P shifted the same way, 6 and 7 zero).
- R3: The ALU codes are 0 for Z+X+Y+cin, 1 for Z−(X+Y+cin), 4 for X xor Z, 5 for X xnor Z, 8 for X and Z, and 12 for X or Z. Every other code gives zero.
- R4: The carry source codes are 0 for the carry bit of `instr`, 1 for the inverted product sign, 2 for the fed-back P sign and 3 for the inverted fed-back P sign. Every other code gives zero.
- R5: A change on `a` or `b` reaches `p` after exactly depth + `M_REG` + `P_REG` rising edges, where depth is the input pipeline depth (0, 1 or 2). With no registers, `p` follows the inputs combinationally.
- R6: `a_cas` and `b_cas` show the input delayed by the tap depth, and the tap depth is clamped to the input pipeline depth. `pc_cas` always equals `p`.
- R7: A change of a control field takes effect at `p` one edge later when that field's register is present.
- R8: A local reset of a stage clears that stage's register to zero at the next edge. `rst_all` clears every register.
- R9: A low local enable holds that stage's register, and a low `ce_all` holds every register.
- R10: When `HAS_C` is 0, C reads as zero whatever is on `c`.
- R11: With the output register present, selecting P as Z accumulates once per edge. With no output register, every P feedback source reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_all | input | 1 | Global synchronous reset, ORed into every local reset |
| ce_all | input | 1 | Global clock enable, ANDed into every local enable |
| rst_a | input | 1 | Reset of both A stages |
| rst_b | input | 1 | Reset of both B stages |
| rst_c | input | 1 | Reset of the C register |
| rst_m | input | 1 | Reset of the product register |
| rst_p | input | 1 | Reset of the output register |
| rst_ctl | input | 1 | Reset of the operand-select and carry-source registers |
| rst_alu | input | 1 | Reset of the ALU code register |
| rst_cin | input | 1 | Reset of the carry bit register |
| ce_a1 | input | 1 | Enable of the first A stage |
| ce_a2 | input | 1 | Enable of the second A stage |
| ce_b1 | input | 1 | Enable of the first B stage |
| ce_b2 | input | 1 | Enable of the second B stage |
| ce_c | input | 1 | Enable of the C register |
| ce_m | input | 1 | Enable of the product register |
| ce_p | input | 1 | Enable of the output register |
| ce_ctl | input | 1 | Enable of the operand-select and carry-source registers |
| ce_alu | input | 1 | Enable of the ALU code register |
| ce_cin | input | 1 | Enable of the carry bit register |
| a | input | A_W | Signed multiplicand |
| b | input | B_W | Signed multiplier |
| c | input | P_W | Additive operand |
| pc_in | input | P_W | Partial sum from the previous slice |
| instr | input | 15 | Packed instruction word |
| p | output | P_W | Result |
| a_cas | output | A_W | Tapped A for the next slice |
| b_cas | output | B_W | Tapped B for the next slice |
| pc_cas | output | P_W | Result for the next slice |

## Verification
The bench drives three instances from one set of inputs.

- **Fully registered instance:** every register is present, with the A tap at 1 and the B tap at 2. It exposes the four-edge data latency, the two-edge control latency, each enable and reset, and accumulation through P.
- **Fully combinational instance:** there are no registers and no C port. It checks the arithmetic with no delay, the zero-reading C and the zero-reading P feedback, including carry sources 2 and 3.
- **Third instance:** it has one A stage, a direct B and an unregistered product, and an A tap of 2 that must clamp to 1. It covers an unequal-depth mix of latencies.

A sweep crosses six operand patterns, including both signed extremes, with four operand selections, eight ALU codes (including undefined ones) and three carry settings.

// File: rtl/mac_slice.sv
module mac_slice #(
  parameter int A_W      = 25,
  parameter int B_W      = 18,
  parameter int P_W      = 48,
  parameter int A_DEPTH  = 2,
  parameter int B_DEPTH  = 2,
  parameter int A_TAP    = 1,
  parameter int B_TAP    = 1,
  parameter bit C_REG    = 1'b1,
  parameter bit M_REG    = 1'b1,
  parameter bit P_REG    = 1'b1,
  parameter bit MODE_REG = 1'b1,
  parameter bit ALU_REG  = 1'b1,
  parameter bit CIN_REG  = 1'b1,
  parameter bit CSEL_REG = 1'b1,
  parameter bit HAS_C    = 1'b1,
  parameter int SHIFT    = 17
) (
  input  logic           clk,
  input  logic           rst_all,
  input  logic           ce_all,
  input  logic           rst_a,
  input  logic           rst_b,
  input  logic           rst_c,
  input  logic           rst_m,
  input  logic           rst_p,
  input  logic           rst_ctl,
  input  logic           rst_alu,
  input  logic           rst_cin,
  input  logic           ce_a1,
  input  logic           ce_a2,
  input  logic           ce_b1,
  input  logic           ce_b2,
  input  logic           ce_c,
  input  logic           ce_m,
  input  logic           ce_p,
  input  logic           ce_ctl,
  input  logic           ce_alu,
  input  logic           ce_cin,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic [P_W-1:0] c,
  input  logic [P_W-1:0] pc_in,
  input  logic [14:0]    instr,
  output logic [P_W-1:0] p,
  output logic [A_W-1:0] a_cas,
  output logic [B_W-1:0] b_cas,
  output logic [P_W-1:0] pc_cas
);
  localparam int M_W  = A_W + B_W;
  localparam int A_TE = (A_TAP > A_DEPTH) ? A_DEPTH : A_TAP;
  localparam int B_TE = (B_TAP > B_DEPTH) ? B_DEPTH : B_TAP;

  // input pipelines
  logic [A_W-1:0] a_r1, a_r2, a_s1, a_op;
  logic [B_W-1:0] b_r1, b_r2, b_s1, b_op;

  always_ff @(posedge clk) begin
    if (rst_all || rst_a) begin
      a_r1 <= '0;
      a_r2 <= '0;
    end else begin
      if (ce_all && ce_a1) a_r1 <= a;
      if (ce_all && ce_a2) a_r2 <= a_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_all || rst_b) begin
      b_r1 <= '0;
      b_r2 <= '0;
    end else begin
      if (ce_all && ce_b1) b_r1 <= b;
      if (ce_all && ce_b2) b_r2 <= b_s1;
    end
  end

  assign a_s1  = (A_DEPTH >= 1) ? a_r1 : a;
  assign a_op  = (A_DEPTH >= 2) ? a_r2 : a_s1;
  assign b_s1  = (B_DEPTH >= 1) ? b_r1 : b;
  assign b_op  = (B_DEPTH >= 2) ? b_r2 : b_s1;
  assign a_cas = (A_TE == 0) ? a : (A_TE == 1) ? a_s1 : a_op;
  assign b_cas = (B_TE == 0) ? b : (B_TE == 1) ? b_s1 : b_op;

  // C operand
  logic [P_W-1:0] c_src, c_q, c_op;
  assign c_src = HAS_C ? c : '0;

  always_ff @(posedge clk) begin
    if (rst_all || rst_c)    c_q <= '0;
    else if (ce_all && ce_c) c_q <= c_src;
  end
  assign c_op = C_REG ? c_q : c_src;

  // multiplier
  logic [M_W-1:0] prod, m_q, m_op;
  logic [P_W-1:0] m_ext;
  assign prod = $signed(a_op) * $signed(b_op);

  always_ff @(posedge clk) begin
    if (rst_all || rst_m)    m_q <= '0;
    else if (ce_all && ce_m) m_q <= prod;
  end
  assign m_op  = M_REG ? m_q : prod;
  assign m_ext = {{(P_W-M_W){m_op[M_W-1]}}, m_op};

  // control fields
  logic [6:0] mode_q, mode_e;
  logic [3:0] alu_q, alu_e;
  logic       cin_q, cin_e;
  logic [2:0] csel_q, csel_e;

  always_ff @(posedge clk) begin
    if (rst_all || rst_ctl) begin
      mode_q <= '0;
      csel_q <= '0;
    end else if (ce_all && ce_ctl) begin
      mode_q <= instr[6:0];
      csel_q <= instr[14:12];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_all || rst_alu)    alu_q <= '0;
    else if (ce_all && ce_alu) alu_q <= instr[10:7];
  end

  always_ff @(posedge clk) begin
    if (rst_all || rst_cin)    cin_q <= 1'b0;
    else if (ce_all && ce_cin) cin_q <= instr[11];
  end

  assign mode_e = MODE_REG ? mode_q : instr[6:0];
  assign csel_e = CSEL_REG ? csel_q : instr[14:12];
  assign alu_e  = ALU_REG  ? alu_q  : instr[10:7];
  assign cin_e  = CIN_REG  ? cin_q  : instr[11];

  // output register and feedback
  logic [P_W-1:0] p_q, p_fb, alu_out;

  always_ff @(posedge clk) begin
    if (rst_all || rst_p)    p_q <= '0;
    else if (ce_all && ce_p) p_q <= alu_out;
  end
  assign p_fb   = P_REG ? p_q : '0;
  assign p      = P_REG ? p_q : alu_out;
  assign pc_cas = p;

  // operand multiplexers
  logic [P_W-1:0] x_op, y_op, z_op;
  logic           carry;

  always_comb begin
    case (mode_e[1:0])
      2'd1:    x_op = m_ext;
      2'd2:    x_op = p_fb;
      2'd3:    x_op = {{(P_W-M_W){1'b0}}, a_op, b_op};
      default: x_op = '0;
    endcase
    case (mode_e[3:2])
      2'd1:    y_op = '1;
      2'd2:    y_op = c_op;
      default: y_op = '0;
    endcase
    case (mode_e[6:4])
      3'd1:    z_op = pc_in;
      3'd2:    z_op = p_fb;
      3'd3:    z_op = c_op;
      3'd4:    z_op = $signed(pc_in) >>> SHIFT;
      3'd5:    z_op = $signed(p_fb) >>> SHIFT;
      default: z_op = '0;
    endcase
    case (csel_e)
      3'd0:    carry = cin_e;
      3'd1:    carry = ~m_ext[P_W-1];
      3'd2:    carry = p_fb[P_W-1];
      3'd3:    carry = ~p_fb[P_W-1];
      default: carry = 1'b0;
    endcase
  end

  // arithmetic / logic unit
  logic [P_W-1:0] carry_w, xyc;
  assign carry_w = {{(P_W-1){1'b0}}, carry};
  assign xyc     = x_op + y_op + carry_w;

  always_comb begin
    case (alu_e)
      4'd0:    alu_out = z_op + xyc;
      4'd1:    alu_out = z_op - xyc;
      4'd4:    alu_out = x_op ^ z_op;
      4'd5:    alu_out = ~(x_op ^ z_op);
      4'd8:    alu_out = x_op & z_op;
      4'd12:   alu_out = x_op | z_op;
      default: alu_out = '0;
    endcase
  end
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk #(
  parameter int A_W      = 25,
  parameter int P_W      = 48,
  parameter int A_DEPTH  = 2,
  parameter int A_TAP    = 1,
  parameter bit P_REG    = 1'b1,
  parameter bit MODE_REG = 1'b1
) (
  input logic           clk,
  input logic           rst_all,
  input logic           ce_all,
  input logic           rst_a,
  input logic           ce_a1,
  input logic           rst_p,
  input logic           ce_p,
  input logic           rst_ctl,
  input logic           ce_ctl,
  input logic [A_W-1:0] a,
  input logic [A_W-1:0] a_cas,
  input logic [P_W-1:0] p,
  input logic [6:0]     mode_e,
  input logic [3:0]     alu_e
);
  localparam int A_TE = (A_TAP > A_DEPTH) ? A_DEPTH : A_TAP;

  if (P_REG) begin : g_p
    p_clear_r8: assert property (@(posedge clk) disable iff (rst_all)
      rst_p |=> (p == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst_all || rst_p)
      !(ce_all && ce_p) |=> $stable(p));

    p_undef_zero_r3: assert property (@(posedge clk) disable iff (rst_all)
      (ce_all && ce_p && !rst_p && !(alu_e inside {4'd0, 4'd1, 4'd4, 4'd5, 4'd8, 4'd12}))
      |=> (p == '0));
  end

  if (A_TE == 1) begin : g_tap
    p_a_tap_r6: assert property (@(posedge clk) disable iff (rst_all)
      (ce_all && ce_a1 && !rst_a) |=> (a_cas == $past(a)));
  end

  if (MODE_REG) begin : g_ctl
    p_ctl_hold_r9: assert property (@(posedge clk) disable iff (rst_all)
      (!(ce_all && ce_ctl) && !rst_ctl) |=> $stable(mode_e));
  end
endmodule

bind mac_slice mac_slice_chk #(
  .A_W(A_W), .P_W(P_W), .A_DEPTH(A_DEPTH), .A_TAP(A_TAP),
  .P_REG(P_REG), .MODE_REG(MODE_REG)
) u_chk (
  .clk(clk), .rst_all(rst_all), .ce_all(ce_all), .rst_a(rst_a), .ce_a1(ce_a1),
  .rst_p(rst_p), .ce_p(ce_p), .rst_ctl(rst_ctl), .ce_ctl(ce_ctl),
  .a(a), .a_cas(a_cas), .p(p), .mode_e(mode_e), .alu_e(alu_e)
);

// File: tb/tb_mac_slice.sv
`timescale 1ns/1ps
module tb_mac_slice;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_all = 1'b1, ce_all = 1'b1;
  logic rst_a = 0, rst_b = 0, rst_c = 0, rst_m = 0, rst_p = 0, rst_ctl = 0, rst_alu = 0, rst_cin = 0;
  logic ce_a1 = 1, ce_a2 = 1, ce_b1 = 1, ce_b2 = 1, ce_c = 1, ce_m = 1, ce_p = 1, ce_ctl = 1, ce_alu = 1, ce_cin = 1;
  logic [24:0] a = '0;
  logic [17:0] b = '0;
  logic [47:0] c = '0, pc_in = '0;
  logic [14:0] instr = '0;

  logic [47:0] p0, p1, p2, pcc0, pcc1, pcc2;
  logic [24:0] ac0, ac1, ac2;
  logic [17:0] bc0, bc1, bc2;

  mac_slice #(.B_TAP(2)) dut (.*, .p(p0), .a_cas(ac0), .b_cas(bc0), .pc_cas(pcc0));

  mac_slice #(.A_DEPTH(0), .B_DEPTH(0), .A_TAP(0), .B_TAP(0), .C_REG(0), .M_REG(0),
              .P_REG(0), .MODE_REG(0), .ALU_REG(0), .CIN_REG(0), .CSEL_REG(0), .HAS_C(0))
    dut_flat (.*, .p(p1), .a_cas(ac1), .b_cas(bc1), .pc_cas(pcc1));

  mac_slice #(.A_DEPTH(1), .B_DEPTH(0), .A_TAP(2), .B_TAP(0), .M_REG(0), .P_REG(1),
              .MODE_REG(0), .ALU_REG(0), .CIN_REG(0), .CSEL_REG(0))
    dut_mix (.*, .p(p2), .a_cas(ac2), .b_cas(bc2), .pc_cas(pcc2));

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  function automatic logic [14:0] mk(input logic [6:0] md, input logic [3:0] al,
                                     input logic ci, input logic [2:0] cs);
    return {cs, ci, al, md};
  endfunction

  function automatic logic [47:0] model(input logic [24:0] ia, input logic [17:0] ib,
      input logic [47:0] ic, input logic [47:0] ipc, input logic [47:0] ipf,
      input logic [14:0] ins);
    logic signed [47:0] pr;
    logic [47:0] x, y, z, s;
    logic cy;
    pr = $signed(ia) * $signed(ib);
    x = (ins[1:0] == 2'd1) ? pr : (ins[1:0] == 2'd2) ? ipf :
        (ins[1:0] == 2'd3) ? {5'b0, ia, ib} : 48'd0;
    y = (ins[3:2] == 2'd1) ? {48{1'b1}} : (ins[3:2] == 2'd2) ? ic : 48'd0;
    case (ins[6:4])
      3'd1: z = ipc;
      3'd2: z = ipf;
      3'd3: z = ic;
      3'd4: z = $signed(ipc) >>> 17;
      3'd5: z = $signed(ipf) >>> 17;
      default: z = 48'd0;
    endcase
    case (ins[14:12])
      3'd0: cy = ins[11];
      3'd1: cy = ~pr[47];
      3'd2: cy = ipf[47];
      3'd3: cy = ~ipf[47];
      default: cy = 1'b0;
    endcase
    s = x + y + {47'd0, cy};
    case (ins[10:7])
      4'd0:  return z + s;
      4'd1:  return z - s;
      4'd4:  return x ^ z;
      4'd5:  return ~(x ^ z);
      4'd8:  return x & z;
      4'd12: return x | z;
      default: return 48'd0;
    endcase
  endfunction

  task automatic load_pattern(input int k);
    case (k)
      0: begin a = 25'd3;        b = 18'd5;        c = 48'd100;             pc_in = 48'd1000; end
      1: begin a = '1;           b = '1;           c = -48'sd7;             pc_in = '1; end
      2: begin a = 25'h0FFFFFF;  b = 18'h1FFFF;    c = 48'h0000_FFFF_0000;  pc_in = 48'h8000_0000_0000; end
      3: begin a = 25'h1000000;  b = 18'h20000;    c = 48'hFFFF_FFFF_FFFF;  pc_in = 48'h1234_5678_9ABC; end
      4: begin a = 25'h1000000;  b = 18'h1FFFF;    c = 48'd0;               pc_in = 48'h7FFF_FFFF_FFFF; end
      default: begin a = 25'd12345; b = -18'sd999; c = 48'h5555_AAAA_5555; pc_in = 48'hF000_0000_0001; end
    endcase
  endtask

  logic [6:0] modes [4];
  logic [3:0] alus  [8];

  initial begin
    modes[0] = 7'b000_00_01; modes[1] = 7'b001_10_01;
    modes[2] = 7'b011_01_11; modes[3] = 7'b100_10_00;
    alus[0] = 4'd0; alus[1] = 4'd1; alus[2] = 4'd4; alus[3] = 4'd5;
    alus[4] = 4'd8; alus[5] = 4'd12; alus[6] = 4'd3; alus[7] = 4'd15;

    tick(); tick();
    chk("R8 reset p", p0, 48'd0);
    chk("R8 reset a_cas", {23'd0, ac0}, 48'd0);
    chk("R8 reset b_cas", {30'd0, bc0}, 48'd0);
    chk("R8 reset mix p", p2, 48'd0);
    rst_all = 1'b0;

    // arithmetic sweep (R1 R2 R3 R4)
    for (int k = 0; k < 6; k++)
      for (int m = 0; m < 4; m++)
        for (int u = 0; u < 8; u++)
          for (int q = 0; q < 3; q++) begin
            load_pattern(k);
            instr = mk(modes[m], alus[u], q == 1, (q == 2) ? 3'd1 : 3'd0);
            #1;
            chk("R1 R2 R3 R4 R10 flat", p1, model(a, b, 48'd0, pc_in, 48'd0, instr));
            repeat (6) tick();
            chk("R1 R2 R3 R4 piped", p0, model(a, b, c, pc_in, 48'd0, instr));
          end

    // latency (R5, R6)
    instr = mk(7'h01, 4'd0, 1'b0, 3'd0);
    a = '0; b = '0; c = '0; pc_in = '0;
    repeat (6) tick();
    a = 25'd3; b = 18'd5;
    #1 chk("R5 flat immediate", p1, 48'd15);
    chk("R6 flat a tap", {23'd0, ac1}, 48'd3);
    tick();
    chk("R6 a tap 1", {23'd0, ac0}, 48'd3);
    chk("R6 b tap 2 early", {30'd0, bc0}, 48'd0);
    chk("R6 clamped tap", {23'd0, ac2}, 48'd3);
    chk("R5 piped edge1", p0, 48'd0);
    chk("R5 mix edge1", p2, 48'd0);
    tick();
    chk("R6 b tap 2", {30'd0, bc0}, 48'd5);
    chk("R5 piped edge2", p0, 48'd0);
    chk("R5 mix edge2", p2, 48'd15);
    tick();
    chk("R5 piped edge3", p0, 48'd0);
    tick();
    chk("R5 piped edge4", p0, 48'd15);
    chk("R6 pc cascade", pcc0, p0);

    // control latency (R7)
    c = 48'd100;
    repeat (4) tick();
    instr = mk(7'b000_10_01, 4'd0, 1'b0, 3'd0);
    tick();
    chk("R7 ctl reg edge1", p0, 48'd15);
    chk("R7 no ctl reg", p2, 48'd115);
    tick();
    chk("R7 ctl reg edge2", p0, 48'd115);

    // enables (R9)
    ce_p = 1'b0; a = 25'd7;
    repeat (5) tick();
    chk("R9 ce_p hold", p0, 48'd115);
    ce_p = 1'b1;
    tick();
    chk("R9 ce_p release", p0, 48'd135);
    ce_all = 1'b0; a = 25'd1;
    repeat (5) tick();
    chk("R9 ce_all hold p", p0, 48'd135);
    chk("R9 ce_all hold a_cas", {23'd0, ac0}, 48'd7);
    ce_all = 1'b1;
    tick();
    chk("R9 ce_all release a_cas", {23'd0, ac0}, 48'd1);
    chk("R9 ce_all pipe p", p0, 48'd135);
    repeat (3) tick();
    chk("R9 ce_all pipe done", p0, 48'd105);

    // local resets (R8)
    rst_p = 1'b1;
    tick();
    chk("R8 rst_p", p0, 48'd0);
    rst_p = 1'b0;
    tick();
    chk("R8 rst_p release", p0, 48'd105);
    rst_a = 1'b1;
    tick();
    chk("R8 rst_a", {23'd0, ac0}, 48'd0);
    rst_a = 1'b0;
    tick();
    chk("R8 rst_a release", {23'd0, ac0}, 48'd1);
    repeat (6) tick();

    // control enable (R9)
    ce_ctl = 1'b0;
    instr = mk(7'h01, 4'd0, 1'b0, 3'd0);
    repeat (4) tick();
    chk("R9 ce_ctl hold", p0, 48'd105);
    ce_ctl = 1'b1;
    repeat (2) tick();
    chk("R9 ce_ctl release", p0, 48'd5);

    // accumulation and feedback (R11)
    a = 25'd3; b = 18'd5;
    repeat (6) tick();
    instr = mk(7'h21, 4'd0, 1'b0, 3'd0);
    rst_p = 1'b1;
    tick();
    chk("R11 acc start", p0, 48'd0);
    chk("R11 mix acc start", p2, 48'd0);
    rst_p = 1'b0;
    for (int n = 1; n <= 3; n++) begin
      tick();
      chk("R11 acc step", p0, 48'(15 * n));
      chk("R11 mix acc step", p2, 48'(15 * n));
    end
    chk("R11 flat feedback zero", p1, 48'd15);

    // carry sources on fed-back P with no P register (R4)
    instr = mk(7'h01, 4'd0, 1'b0, 3'd3);
    #1 chk("R4 inverted P sign", p1, 48'd16);
    instr = mk(7'h01, 4'd0, 1'b0, 3'd2);
    #1 chk("R4 P sign", p1, 48'd15);
    instr = mk(7'h01, 4'd0, 1'b1, 3'd6);
    #1 chk("R4 undefined source", p1, 48'd15);

    // absent C port (R10)
    instr = mk(7'b000_10_01, 4'd0, 1'b0, 3'd0);
    c = 48'd100;
    #1 chk("R10 C ignored", p1, 48'd15);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule